// File: doc/BRIEF.md
# Saturating Branch Sample Record Buffer

This block captures retired taken branches as pairs of source and target addresses in a small register array. It fills the array once, from its next-write index up to the last slot, and then stops. It does not wrap around to overwrite older pairs. When the last slot is written, the block clears its own recording enable. Software then reads the captured pairs through a simple register port.

A single control/status word holds the recording enable, a flag that says at least one branch was captured, the next-write index and a counter-selection field. A sampling counter that overflows while recording is on does not interrupt at once. The interrupt is held until the array is full or until software switches recording off. After that the interrupt line stays high until software acknowledges it. Software may also write any entry word directly, for example to plant a sentinel value. Such a write leaves the index and the flag untouched.

Register map (word addresses):

- Entry `i` source: address `2*i`.
- Entry `i` target: address `2*i+1`.
- Control/status word: address `2*DEPTH`.
- Acknowledge: address `2*DEPTH+1`.

Top module: `brs_sample_buffer`

## Requirements
- R1: After synchronous reset, the following hold:
  - The control word reads 0x18.
  - Every entry word reads 0.
  - `irq_o` is low.
- R2: Entry `i` is addressed as two words. The source is at address `2*i` and the target is at address `2*i+1`. Addresses 2*DEPTH (32) and 2*DEPTH+1 (33) are the control word and the acknowledge. Any other address reads 0.
- R3: The control word has the following layout:
  - Bit 2 is the enable.
  - Bits 4:3 always read 11b, whatever was written.
  - Bit 5 is the captured flag.
  - Bits 19:16 are the next-write index.
  - Bits 26:24 are the counter selection.
  - All other bits read 0.
  - A write to the control word loads all four fields from the written data.
- R4: A `br_valid` strobe while enabled does three things. It stores `br_from`/`br_to` into the entry at the next-write index, it advances the index by one, and it sets the captured flag. All changes are visible the cycle after the strobe.
- R5: A `br_valid` strobe while disabled changes no entry, no index and no flag.
- R6: Recording into entry DEPTH-1 returns the index to 0 and clears the enable. Later strobes are ignored until software sets the enable again.
- R7: A software write to an entry word changes only that word. It leaves the index and the captured flag as they were.
- R8: A counter overflow while enabled keeps `irq_o` low. `irq_o` rises in the cycle after the strobe that fills the last entry.
- R9: If software clears the enable while an overflow is held, `irq_o` rises in the cycle after that write.
- R10: A counter overflow while disabled raises `irq_o` in the next cycle.
- R11: `irq_o` stays high until a write to the acknowledge address, which drops it the next cycle. An overflow in the same cycle as the acknowledge wins.
- R12: A strobe in the same cycle as a control-word write is applied after the write. It uses the newly written enable and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A taken branch retired this cycle |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| ovf_pulse | input | 1 | Sampling counter overflowed this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Held overflow interrupt, level |

## Verification
The bench runs recording from several start indices, both a fresh start at 0 and a late start near the end. This shows that the saturation point depends on the index and not on a count of branches. Address patterns of all ones, alternating bits and small counters expose swapped source and target words and wrong entry selection. Overflow is tried while enabled, while disabled, together with an acknowledge, and followed by a software disable. These cases separate the held interrupt, the immediate interrupt and the released interrupt. Strobes that coincide with control writes and with direct entry writes show the order in which the writes are applied.

// File: rtl/brs_pkg.sv
package brs_pkg;

    localparam int CSR_W = 64;
    localparam int IDX_W = 4;
    localparam int SEL_W = 3;

    // control word bit positions
    localparam int B_EN   = 2;
    localparam int B_VB   = 5;
    localparam int B_IDX  = 16;
    localparam int B_SEL  = 24;

    typedef struct packed {
        logic             en;
        logic             vb;
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ENTRY,
        ACC_CTL,
        ACC_ACK
    } acc_e;

    function automatic logic [CSR_W-1:0] ctl_pack(input ctl_t c);
        logic [CSR_W-1:0] w;
        w = '0;
        w[4:3] = 2'b11;
        w[B_EN] = c.en;
        w[B_VB] = c.vb;
        w[B_IDX +: IDX_W] = c.idx;
        w[B_SEL +: SEL_W] = c.sel;
        return w;
    endfunction

    function automatic ctl_t ctl_unpack(input logic [CSR_W-1:0] w);
        ctl_t c;
        c.en  = w[B_EN];
        c.vb  = w[B_VB];
        c.idx = w[B_IDX +: IDX_W];
        c.sel = w[B_SEL +: SEL_W];
        return c;
    endfunction

endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl
    import brs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CSR_W-1:0] ctl_wdata,
    input  logic             ack_wr,
    input  logic             br_valid,
    input  logic             ovf,
    output ctl_t             ctl_q,
    output logic             rec_fire,
    output logic [IDX_W-1:0] rec_idx,
    output logic             irq
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    ctl_t base, nxt;
    logic pend_q, pend_d;

    always_comb begin
        base = ctl_wr ? ctl_unpack(ctl_wdata) : ctl_q;
        rec_fire = br_valid && base.en;
        rec_idx = base.idx;
        nxt = base;
        if (rec_fire) begin
            nxt.vb = 1'b1;
            if (base.idx == IDX_LAST) begin
                nxt.idx = '0;
                nxt.en = 1'b0;
            end else begin
                nxt.idx = base.idx + 1'b1;
            end
        end
    end

    always_comb begin
        if (ovf)
            pend_d = 1'b1;
        else if (ack_wr)
            pend_d = 1'b0;
        else
            pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            ctl_q  <= nxt;
            pend_q <= pend_d;
        end
    end

    assign irq = pend_q & ~ctl_q.en;

    // R4: each recorded branch steps the index by one, wrapping after the last slot
    p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rec_fire) && !$past(rst) |->
            ctl_q.idx == (($past(rec_idx) == IDX_LAST) ? '0 : $past(rec_idx) + 1'b1));

    // R6: filling the last slot stops recording
    p_full_stops_r6: assert property (@(posedge clk) disable iff (rst)
        rec_fire && rec_idx == IDX_LAST |=> !ctl_q.en);

    // R8: no interrupt reaches the pin while recording is on
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_q.en |-> !irq);

    // R9: a held overflow is released when enable drops
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        pend_q && $fell(ctl_q.en) |-> irq);

    // R11: acknowledge without fresh overflow clears the line
    p_ack_r11: assert property (@(posedge clk) disable iff (rst)
        ack_wr && !ovf |=> !irq);

endmodule

// File: rtl/brs_store.sv
module brs_store
    import brs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_entry,
    input  logic             sw_is_to,
    input  logic [AW-1:0]    sw_wdata,
    input  logic             rec_we,
    input  logic [IDX_W-1:0] rec_entry,
    input  logic [AW-1:0]    rec_from,
    input  logic [AW-1:0]    rec_to,
    input  logic [IDX_W-1:0] rd_entry,
    input  logic             rd_is_to,
    output logic [AW-1:0]    rd_word
);

    logic [AW-1:0] from_q [DEPTH];
    logic [AW-1:0] to_q   [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(e);
        logic hit_rec, hit_sw;
        assign hit_rec = rec_we && (rec_entry == SLOT);
        assign hit_sw  = sw_we && (sw_entry == SLOT);

        always_ff @(posedge clk) begin
            if (rst) begin
                from_q[e] <= '0;
                to_q[e]   <= '0;
            end else if (hit_rec) begin
                from_q[e] <= rec_from;
                to_q[e]   <= rec_to;
            end else if (hit_sw) begin
                if (sw_is_to)
                    to_q[e] <= sw_wdata;
                else
                    from_q[e] <= sw_wdata;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_entry == IDX_W'(k))
                rd_word = rd_is_to ? to_q[k] : from_q[k];
        end
    end

endmodule

// File: rtl/brs_sample_buffer.sv
module brs_sample_buffer
    import brs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 64,
    parameter int RA_W  = $clog2(2 * DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_valid,
    input  logic [AW-1:0]    br_from,
    input  logic [AW-1:0]    br_to,
    input  logic             ovf_pulse,
    input  logic             reg_wr,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [CSR_W-1:0] reg_wdata,
    output logic [CSR_W-1:0] reg_rdata,
    output logic             irq_o
);

    localparam logic [RA_W-1:0] A_CTL = RA_W'(2 * DEPTH);
    localparam logic [RA_W-1:0] A_ACK = RA_W'(2 * DEPTH + 1);

    acc_e             acc;
    logic [IDX_W-1:0] entry_sel;
    logic             is_to;
    ctl_t             ctl_q;
    logic             rec_fire;
    logic [IDX_W-1:0] rec_idx;
    logic [AW-1:0]    entry_word;

    always_comb begin
        if (reg_addr < A_CTL)
            acc = ACC_ENTRY;
        else if (reg_addr == A_CTL)
            acc = ACC_CTL;
        else if (reg_addr == A_ACK)
            acc = ACC_ACK;
        else
            acc = ACC_NONE;
    end

    assign entry_sel = IDX_W'(reg_addr >> 1);
    assign is_to = reg_addr[0];

    brs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (reg_wr && acc == ACC_CTL),
        .ctl_wdata(reg_wdata),
        .ack_wr   (reg_wr && acc == ACC_ACK),
        .br_valid (br_valid),
        .ovf      (ovf_pulse),
        .ctl_q    (ctl_q),
        .rec_fire (rec_fire),
        .rec_idx  (rec_idx),
        .irq      (irq_o)
    );

    brs_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (reg_wr && acc == ACC_ENTRY),
        .sw_entry (entry_sel),
        .sw_is_to (is_to),
        .sw_wdata (AW'(reg_wdata)),
        .rec_we   (rec_fire),
        .rec_entry(rec_idx),
        .rec_from (br_from),
        .rec_to   (br_to),
        .rd_entry (entry_sel),
        .rd_is_to (is_to),
        .rd_word  (entry_word)
    );

    always_comb begin
        unique case (acc)
            ACC_ENTRY: reg_rdata = CSR_W'(entry_word);
            ACC_CTL:   reg_rdata = ctl_pack(ctl_q);
            default:   reg_rdata = '0;
        endcase
    end

    // R3: reserved pair always reads as ones
    p_rsvd_ones_r3: assert property (@(posedge clk) disable iff (rst)
        acc == ACC_CTL |-> reg_rdata[4:3] == 2'b11);

    // R7: direct entry writes leave index and flag alone
    p_direct_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        reg_wr && acc == ACC_ENTRY && !br_valid |=> $stable(ctl_q.idx) && $stable(ctl_q.vb));

    // R5: strobes while disabled are dropped
    p_off_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        br_valid && !ctl_q.en && !(reg_wr && acc == ACC_CTL) |=> $stable(ctl_q.idx));

endmodule

// File: tb/sim_brs_sample_buffer.sv
module sim_brs_sample_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int D   = 16;
    localparam int ACTL = 2 * D;
    localparam int AACK = 2 * D + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 1'b0;
    logic [63:0] br_from = '0;
    logic [63:0] br_to = '0;
    logic        ovf_pulse = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // behavioural reference
    logic [63:0] m_from[D];
    logic [63:0] m_to[D];
    bit m_en, m_vb, m_pend;
    int m_idx, m_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    brs_sample_buffer u0 (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .ovf_pulse(ovf_pulse), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [63:0] m_read(int a);
        if (a < ACTL)
            return (a % 2) ? m_to[a/2] : m_from[a/2];
        if (a == ACTL)
            return 64'h18 | (64'(m_en) << 2) | (64'(m_vb) << 5)
                 | (64'(m_idx) << 16) | (64'(m_sel) << 24);
        return 64'h0;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < D; i++) begin m_from[i] = '0; m_to[i] = '0; end
        m_en = 0; m_vb = 0; m_pend = 0; m_idx = 0; m_sel = 0;
    endtask

    task automatic m_step();
        int a;
        a = int'(reg_addr);
        if (reg_wr && a == ACTL) begin
            m_en = reg_wdata[2]; m_vb = reg_wdata[5];
            m_idx = int'(reg_wdata[19:16]); m_sel = int'(reg_wdata[26:24]);
        end
        if (reg_wr && a < ACTL) begin
            if (a % 2) m_to[a/2] = reg_wdata; else m_from[a/2] = reg_wdata;
        end
        if (br_valid && m_en) begin
            m_from[m_idx] = br_from; m_to[m_idx] = br_to; m_vb = 1;
            if (m_idx == D - 1) begin m_idx = 0; m_en = 0; end
            else m_idx = m_idx + 1;
        end
        if (ovf_pulse) m_pend = 1;
        else if (reg_wr && a == AACK) m_pend = 0;
    endtask

    task automatic check(string tag);
        bit exp_irq;
        logic [63:0] exp_rd;
        exp_irq = m_pend && !m_en;
        exp_rd = m_read(int'(reg_addr));
        n_tests++;
        if (irq_o !== exp_irq) begin
            n_fail++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq_o, exp_irq);
        end
        n_tests++;
        if (reg_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s rdata@%0d actual=%h expected=%h", tag, reg_addr, reg_rdata, exp_rd);
        end
    endtask

    // one clock: drive at negedge, model at edge, compare at next negedge
    task automatic cyc(bit we, int a, logic [63:0] wd, bit br, logic [63:0] f,
                       logic [63:0] t, bit ov, string tag);
        reg_wr = we; reg_addr = 6'(a); reg_wdata = wd;
        br_valid = br; br_from = f; br_to = t; ovf_pulse = ov;
        @(posedge clk);
        m_step();
        @(negedge clk);
        reg_wr = 0; br_valid = 0; ovf_pulse = 0;
        check(tag);
    endtask

    task automatic rd(int a, string tag);
        cyc(0, a, '0, 0, '0, '0, 0, tag);
    endtask

    task automatic wr(int a, logic [63:0] d, string tag);
        cyc(1, a, d, 0, '0, '0, 0, tag);
    endtask

    task automatic br(logic [63:0] f, logic [63:0] t, int a, string tag);
        cyc(0, a, '0, 1, f, t, 0, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(ACTL, "R1");
        rd(0, "R1");
        rd(2*D-1, "R1");
        rd(40, "R2");
        // R3 enable with counter select 5, reserved bits written as zero
        wr(ACTL, 64'h0000_0000_0500_0004, "R3");
        rd(ACTL, "R3");
        // R4 / R2 record three branches with distinct patterns
        br(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, ACTL, "R4");
        br(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, ACTL, "R4");
        br(64'h0000_0000_0000_1230, 64'h0000_0000_0000_4560, ACTL, "R4");
        for (int a = 0; a < 6; a++) rd(a, "R2");
        // R5 disable, strobe dropped, flag and index kept
        wr(ACTL, 64'h0, "R5");
        br(64'hDEAD, 64'hBEEF, ACTL, "R5");
        rd(6, "R5");
        rd(7, "R5");
        // R7 sentinel write to a target word
        wr(3, 64'hFFFF_FFFF_FFFF_FFFE, "R7");
        rd(ACTL, "R7");
        rd(3, "R7");
        // R10 overflow while disabled, R11 hold until ack
        cyc(0, ACTL, '0, 0, '0, '0, 1, "R10");
        rd(ACTL, "R11");
        rd(ACTL, "R11");
        wr(AACK, 64'h1, "R11");
        rd(ACTL, "R11");
        // R11 overflow coinciding with ack wins
        cyc(1, AACK, 64'h1, 0, '0, '0, 1, "R11");
        wr(AACK, 64'h1, "R11");
        // R8 / R6 late start at index 12, overflow held until full
        wr(ACTL, 64'h0000_0000_000C_0024, "R6");
        cyc(0, ACTL, '0, 0, '0, '0, 1, "R8");
        for (int i = 0; i < 4; i++)
            br(64'h1000 + 64'(i), 64'h2000 + 64'(i), ACTL, "R8");
        br(64'h7777, 64'h8888, ACTL, "R6");
        for (int a = 24; a < 32; a++) rd(a, "R6");
        rd(0, "R6");
        wr(AACK, 64'h0, "R11");
        // R9 software disable releases held overflow
        wr(ACTL, 64'h0000_0000_0000_0004, "R9");
        cyc(0, ACTL, '0, 0, '0, '0, 1, "R8");
        br(64'h4242, 64'h2424, ACTL, "R8");
        wr(ACTL, 64'h0000_0000_0001_0020, "R9");
        rd(ACTL, "R9");
        wr(AACK, 64'h0, "R11");
        // R12 strobe with control write: new enable and index used
        cyc(1, ACTL, 64'h0000_0000_0007_0004, 1, 64'hCAFE, 64'hF00D, 0, "R12");
        rd(14, "R12");
        rd(15, "R12");
        // R12 strobe with disabling write is dropped
        cyc(1, ACTL, 64'h0000_0000_0009_0000, 1, 64'h1111, 64'h2222, 0, "R12");
        rd(18, "R12");
        // R7 entry write and branch to same slot: branch wins
        wr(ACTL, 64'h0000_0000_0002_0004, "R7");
        cyc(1, 4, 64'h9999, 1, 64'hABCD, 64'hDCBA, 0, "R7");
        rd(4, "R7");
        rd(5, "R7");
        finish_run();
    end

endmodule